// File: doc/BRIEF.md
# Parallel Host Byte Port with Word Buffers

This block is the slave side of a strobe-based parallel host interface. An external processor reaches the chip over an 8-bit byte bus. It uses an active-low chip select, a separate active-low read strobe and write strobe, a byte-half select and a status select. Through these pins the host fills a 16-bit input word for the on-chip core, empties a 16-bit output word that the core has loaded, and polls a small status byte. All host pins are asynchronous to the core. They pass through a two-stage synchronizer, and the block then finds the start and end of each transfer as edges of "chip select low AND strobe low".

A transfer exists only while chip select and its strobe are both low. Either signal can open the transfer, whichever falls last, and either can close it, whichever rises first. The byte-half and status selects are captured when the transfer opens. Write data is taken when the transfer closes. A word moves as two byte transfers. Writing the upper half completes the input word and hands it to the core. Reading the upper half of the output word frees that buffer for the core.

Top module: `hostport_par`

## Requirements
- R1: After reset the byte bus is not driven (`hp_data_oe` = 0), both buffer-full flags are 0, the overrun bit is 0 and `core_in_word` is 0.
- R2: `hp_data_oe` is 1 only while a read transfer is open, meaning chip select and read strobe are both low. Either of the two may be the last to fall and either may be the first to rise. A strobe without chip select opens no transfer. The bus is released within four clocks of the closing edge.
- R3: On a data read, `hp_hi` = 0 returns output-word bits [7:0] and `hp_hi` = 1 returns bits [15:8]. The select is captured when the transfer opens, and a later change during the transfer does not alter the returned byte.
- R4: On a read with `hp_stat` = 1 the returned byte is status. Bit 0 is input-buffer-full, bit 1 is output-buffer-full, bit 2 is overrun and bits 7:3 are 0.
- R5: Write data is taken when the write transfer closes. A write with `hp_hi` = 0 stores the low byte. A write with `hp_hi` = 1 places {written byte, stored low byte} on `core_in_word` and sets input-buffer-full.
- R6: A write with `hp_stat` = 1 changes neither the stored low byte, nor the input word, nor any flag.
- R7: A one-cycle `core_out_load` copies `core_out_word_i` into the output word and sets output-buffer-full. The close of a host read of the upper half (`hp_hi` = 1, `hp_stat` = 0) clears the flag. If a load falls in the same cycle as that clear, the flag stays set.
- R8: A one-cycle `core_in_take` clears input-buffer-full. If it falls in the same cycle as an upper-half commit, the flag stays set and no overrun is recorded.
- R9: An upper-half commit while input-buffer-full is set and no take is present overwrites the input word and sets the overrun bit. The overrun bit is then cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_sel_n | input | 1 | Host chip select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_hi | input | 1 | Byte-half select, 1 = bits [15:8] |
| hp_stat | input | 1 | Status select, 1 = status byte |
| hp_data_i | input | BYTE_W | Byte bus as driven by the host |
| hp_data_o | output | BYTE_W | Byte returned to the host on reads |
| hp_data_oe | output | 1 | Drive enable for the byte bus |
| core_in_word | output | 2*BYTE_W | Last word committed by the host |
| core_in_full | output | 1 | Input-buffer-full flag |
| core_in_take | input | 1 | Core read pulse, clears input-buffer-full |
| core_out_word_i | input | 2*BYTE_W | Word the core offers to the host |
| core_out_load | input | 1 | Core write pulse for the output word |
| core_out_full | output | 1 | Output-buffer-full flag |

## Verification
Two pairs of events can land in the same clock. The core take can coincide with a host upper-half commit, and a core load can coincide with the close of a host upper-half read. The bench places the core pulse exactly in the cycle where the synchronized closing edge is seen. It counts the two synchronizer stages from the negative edge at which the pin rises. It then judges the result through the status byte: input-buffer-full must stay 1 with overrun 0, and output-buffer-full must stay 1 with the newly loaded word readable.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    // Status byte bit positions (host-visible encoding)
    localparam int STAT_IBF = 0;
    localparam int STAT_OBF = 1;
    localparam int STAT_OVR = 2;

    // Index of each strobe in the transfer detector array
    localparam int DIR_RD = 0;
    localparam int DIR_WR = 1;
    localparam int N_DIR  = 2;

    // Selects captured when a transfer opens
    typedef struct packed {
        logic hi;
        logic stat;
    } sel_t;

endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hostport_edge.sv
module hostport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic strb_n_i,
    output logic act_o,
    output logic start_o,
    output logic end_o
);

    logic act_d;
    logic act_q;

    // Open only while both are low: last to fall opens, first to rise closes
    always_comb begin
        act_d   = ~sel_n_i & ~strb_n_i;
        start_o = act_d & ~act_q;
        end_o   = ~act_d & act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_o = act_q;

endmodule

// File: rtl/hostport_bufs.sv
module hostport_bufs
    import hostport_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end_i,
    input  sel_t              wr_sel_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              rd_end_i,
    input  sel_t              rd_sel_i,
    input  logic              take_i,
    input  logic              load_i,
    input  logic [2*BYTE_W-1:0] load_word_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic [2*BYTE_W-1:0] in_word_o,
    output logic              ibf_o,
    output logic              obf_o,
    output logic              ovr_o
);

    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [WORD_W-1:0] in_word;
        logic [WORD_W-1:0] out_word;
        logic              ibf;
        logic              obf;
        logic              ovr;
    } buf_t;

    buf_t st_d, st_q;

    logic              commit;
    logic              lo_write;
    logic              obf_clr;
    logic [BYTE_W-1:0] stat_byte;

    always_comb begin
        commit   = wr_end_i & wr_sel_i.hi & ~wr_sel_i.stat;
        lo_write = wr_end_i & ~wr_sel_i.hi & ~wr_sel_i.stat;
        obf_clr  = rd_end_i & rd_sel_i.hi & ~rd_sel_i.stat;

        st_d = st_q;
        if (lo_write) begin
            st_d.lo = wr_byte_i;
        end
        if (commit) begin
            st_d.in_word = {wr_byte_i, st_q.lo};
            st_d.ibf     = 1'b1;
            st_d.ovr     = st_q.ovr | (st_q.ibf & ~take_i);
        end else if (take_i) begin
            st_d.ibf = 1'b0;
        end
        if (load_i) begin
            st_d.out_word = load_word_i;
            st_d.obf      = 1'b1;
        end else if (obf_clr) begin
            st_d.obf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_byte           = '0;
        stat_byte[STAT_IBF] = st_q.ibf;
        stat_byte[STAT_OBF] = st_q.obf;
        stat_byte[STAT_OVR] = st_q.ovr;
        if (rd_sel_i.stat) begin
            rd_byte_o = stat_byte;
        end else if (rd_sel_i.hi) begin
            rd_byte_o = st_q.out_word[WORD_W-1:BYTE_W];
        end else begin
            rd_byte_o = st_q.out_word[BYTE_W-1:0];
        end
    end

    assign in_word_o = st_q.in_word;
    assign ibf_o     = st_q.ibf;
    assign obf_o     = st_q.obf;
    assign ovr_o     = st_q.ovr;

endmodule

// File: rtl/hostport_par.sv
module hostport_par
    import hostport_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hp_sel_n,
    input  logic                hp_rd_n,
    input  logic                hp_wr_n,
    input  logic                hp_hi,
    input  logic                hp_stat,
    input  logic [BYTE_W-1:0]   hp_data_i,
    output logic [BYTE_W-1:0]   hp_data_o,
    output logic                hp_data_oe,
    output logic [2*BYTE_W-1:0] core_in_word,
    output logic                core_in_full,
    input  logic                core_in_take,
    input  logic [2*BYTE_W-1:0] core_out_word_i,
    input  logic                core_out_load,
    output logic                core_out_full
);

    localparam int                PIN_W   = BYTE_W + 5;
    localparam logic [PIN_W-1:0]  PIN_RST = {{(BYTE_W + 2){1'b0}}, 3'b111};

    logic [PIN_W-1:0]  pins_s;
    logic              sel_n_s;
    logic              rd_n_s;
    logic              wr_n_s;
    logic              hi_s;
    logic              stat_s;
    logic [BYTE_W-1:0] data_s;

    hostport_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({hp_data_i, hp_stat, hp_hi, hp_wr_n, hp_rd_n, hp_sel_n}),
        .q_o   (pins_s)
    );

    assign {data_s, stat_s, hi_s, wr_n_s, rd_n_s, sel_n_s} = pins_s;

    logic [N_DIR-1:0] strb_n_s;
    logic [N_DIR-1:0] act;
    logic [N_DIR-1:0] start;
    logic [N_DIR-1:0] stop;

    assign strb_n_s[DIR_RD] = rd_n_s;
    assign strb_n_s[DIR_WR] = wr_n_s;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        hostport_edge i_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_n_i  (sel_n_s),
            .strb_n_i (strb_n_s[g]),
            .act_o    (act[g]),
            .start_o  (start[g]),
            .end_o    (stop[g])
        );
    end

    logic rd_start;
    logic rd_end;
    logic wr_end;
    logic rd_act;

    assign rd_start = start[DIR_RD];
    assign rd_end   = stop[DIR_RD];
    assign wr_end   = stop[DIR_WR];
    assign rd_act   = act[DIR_RD];

    // Selects captured at transfer open, held until it closes
    typedef struct packed {
        sel_t rd;
        sel_t wr;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (start[DIR_RD]) begin
            lat_d.rd.hi   = hi_s;
            lat_d.rd.stat = stat_s;
        end
        if (start[DIR_WR]) begin
            lat_d.wr.hi   = hi_s;
            lat_d.wr.stat = stat_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    logic overrun;

    hostport_bufs #(
        .BYTE_W (BYTE_W)
    ) i_bufs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_end_i    (wr_end),
        .wr_sel_i    (lat_q.wr),
        .wr_byte_i   (data_s),
        .rd_end_i    (rd_end),
        .rd_sel_i    (lat_q.rd),
        .take_i      (core_in_take),
        .load_i      (core_out_load),
        .load_word_i (core_out_word_i),
        .rd_byte_o   (hp_data_o),
        .in_word_o   (core_in_word),
        .ibf_o       (core_in_full),
        .obf_o       (core_out_full),
        .ovr_o       (overrun)
    );

    assign hp_data_oe = rd_act;

endmodule

// File: rtl/hostport_par_chk.sv
module hostport_par_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hp_data_oe,
    input logic [BYTE_W-1:0]   hp_data_o,
    input logic [2*BYTE_W-1:0] core_in_word,
    input logic                core_in_full,
    input logic                core_in_take,
    input logic                core_out_load,
    input logic                core_out_full,
    input logic                rd_start,
    input logic                rd_end,
    input logic                wr_end,
    input logic                rd_hi,
    input logic                rd_stat,
    input logic                wr_hi,
    input logic                wr_stat,
    input logic                overrun
);

    a_r2_drive_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> hp_data_oe);

    a_r2_release_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        rd_end |=> !hp_data_oe);

    a_r4_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_data_oe && rd_stat) |-> ((hp_data_o >> 3) == '0));

    a_r5_commit_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end && wr_hi && !wr_stat) |=> core_in_full);

    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end && wr_stat && !core_in_take) |=>
            ($stable(core_in_word) && $stable(core_in_full)));

    a_r7_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_load |=> core_out_full);

    a_r7_hi_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && rd_hi && !rd_stat && !core_out_load) |=> !core_out_full);

    a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (core_in_take && !(wr_end && wr_hi && !wr_stat)) |=> !core_in_full);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind hostport_par hostport_par_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hp_data_oe    (hp_data_oe),
    .hp_data_o     (hp_data_o),
    .core_in_word  (core_in_word),
    .core_in_full  (core_in_full),
    .core_in_take  (core_in_take),
    .core_out_load (core_out_load),
    .core_out_full (core_out_full),
    .rd_start      (rd_start),
    .rd_end        (rd_end),
    .wr_end        (wr_end),
    .rd_hi         (lat_q.rd.hi),
    .rd_stat       (lat_q.rd.stat),
    .wr_hi         (lat_q.wr.hi),
    .wr_stat       (lat_q.wr.stat),
    .overrun       (overrun)
);

// File: tb/test_hostport_par.sv
module test_hostport_par;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_sel_n = 1'b1;
    logic        hp_rd_n = 1'b1;
    logic        hp_wr_n = 1'b1;
    logic        hp_hi = 1'b0;
    logic        hp_stat = 1'b0;
    logic [7:0]  hp_data_i = 8'h00;
    logic [7:0]  hp_data_o;
    logic        hp_data_oe;
    logic [15:0] core_in_word;
    logic        core_in_full;
    logic        core_in_take = 1'b0;
    logic [15:0] core_out_word_i = 16'h0000;
    logic        core_out_load = 1'b0;
    logic        core_out_full;

    always #5 clk = ~clk;

    hostport_par i_hostport_par (
        .clk             (clk),
        .rst_n           (rst_n),
        .hp_sel_n        (hp_sel_n),
        .hp_rd_n         (hp_rd_n),
        .hp_wr_n         (hp_wr_n),
        .hp_hi           (hp_hi),
        .hp_stat         (hp_stat),
        .hp_data_i       (hp_data_i),
        .hp_data_o       (hp_data_o),
        .hp_data_oe      (hp_data_oe),
        .core_in_word    (core_in_word),
        .core_in_full    (core_in_full),
        .core_in_take    (core_in_take),
        .core_out_word_i (core_out_word_i),
        .core_out_load   (core_out_load),
        .core_out_full   (core_out_full)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hp_sel_n = 1'b1; hp_rd_n = 1'b1; hp_wr_n = 1'b1;
        core_in_take = 1'b0; core_out_load = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // side: 0 none, 1 core load of side_w, 2 core take -- placed in the close-detect cycle
    task automatic host_xfer(input bit is_rd, input bit hi, input bit stat, input logic [7:0] d,
                             input int mode, input int side, input logic [15:0] side_w,
                             output logic [7:0] got);
        @(negedge clk);
        hp_hi = hi; hp_stat = stat; hp_data_i = d;
        if (mode == 0) begin
            hp_sel_n = 1'b0;
            repeat (3) @(negedge clk);
            if (is_rd) hp_rd_n = 1'b0; else hp_wr_n = 1'b0;
        end else begin
            if (is_rd) hp_rd_n = 1'b0; else hp_wr_n = 1'b0;
            repeat (3) @(negedge clk);
            hp_sel_n = 1'b0;
        end
        repeat (6) @(negedge clk);
        got = hp_data_o;
        chk(hp_data_oe == is_rd, "R2 drive enable while open", 32'(hp_data_oe), 32'(is_rd));
        if (mode == 0) begin
            if (is_rd) hp_rd_n = 1'b1; else hp_wr_n = 1'b1;
        end else begin
            hp_sel_n = 1'b1;
        end
        @(posedge clk); @(posedge clk); @(negedge clk);
        if (side == 1) begin core_out_word_i = side_w; core_out_load = 1'b1; end
        if (side == 2) core_in_take = 1'b1;
        @(posedge clk); @(negedge clk);
        core_out_load = 1'b0; core_in_take = 1'b0;
        hp_sel_n = 1'b1; hp_rd_n = 1'b1; hp_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(hp_data_oe == 1'b0, "R2 bus released after close", 32'(hp_data_oe), 32'h0);
    endtask

    task automatic core_load(input logic [15:0] w);
        @(negedge clk); core_out_word_i = w; core_out_load = 1'b1;
        @(negedge clk); core_out_load = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic core_take();
        @(negedge clk); core_in_take = 1'b1;
        @(negedge clk); core_in_take = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // op: 0 host write, 1 host read (compare exp), 2 core load dat, 3 core take (compare word with dat)
    typedef struct packed {
        logic [2:0]  op;
        logic        hi;
        logic        stat;
        logic [15:0] dat;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 1'b0, 1'b0, 16'hA55A, 8'h00},  // R7 load
        '{3'd1, 1'b0, 1'b1, 16'h0000, 8'h02},  // R4 status: obf
        '{3'd1, 1'b0, 1'b0, 16'h0000, 8'h5A},  // R3 low half
        '{3'd1, 1'b1, 1'b0, 16'h0000, 8'hA5},  // R3 high half
        '{3'd1, 1'b0, 1'b1, 16'h0000, 8'h00},  // R7 obf cleared
        '{3'd0, 1'b0, 1'b0, 16'h0034, 8'h00},  // R5 low byte
        '{3'd0, 1'b0, 1'b1, 16'h00FF, 8'h00},  // R6 ignored write
        '{3'd0, 1'b1, 1'b0, 16'h0012, 8'h00},  // R5 commit
        '{3'd1, 1'b0, 1'b1, 16'h0000, 8'h01},  // R4 status: ibf
        '{3'd3, 1'b0, 1'b0, 16'h1234, 8'h00},  // R5 R6 word
        '{3'd1, 1'b0, 1'b1, 16'h0000, 8'h00},  // R8 cleared
        '{3'd0, 1'b0, 1'b0, 16'h0078, 8'h00},
        '{3'd0, 1'b1, 1'b0, 16'h0056, 8'h00},
        '{3'd0, 1'b0, 1'b0, 16'h009A, 8'h00},
        '{3'd0, 1'b1, 1'b0, 16'h00BC, 8'h00},  // R9 overrun
        '{3'd1, 1'b0, 1'b1, 16'h0000, 8'h05},  // R9 status
        '{3'd3, 1'b0, 1'b0, 16'hBC9A, 8'h00},  // R9 overwritten word
        '{3'd1, 1'b0, 1'b1, 16'h0000, 8'h04}   // R9 sticky
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1 R2 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] got;
        do_reset();

        // R1 reset state
        chk(hp_data_oe == 1'b0, "R1 oe after reset", 32'(hp_data_oe), 32'h0);
        chk(core_in_full == 1'b0 && core_out_full == 1'b0, "R1 flags after reset",
            32'({core_in_full, core_out_full}), 32'h0);
        chk(core_in_word == 16'h0000, "R1 input word after reset", 32'(core_in_word), 32'h0);

        // R2 strobes without chip select open nothing
        @(negedge clk); hp_rd_n = 1'b0; hp_wr_n = 1'b0; hp_hi = 1'b1; hp_data_i = 8'h77;
        repeat (8) @(negedge clk);
        chk(hp_data_oe == 1'b0, "R2 read strobe alone", 32'(hp_data_oe), 32'h0);
        hp_rd_n = 1'b1; hp_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(core_in_full == 1'b0, "R2 write strobe alone", 32'(core_in_full), 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                3'd0: host_xfer(1'b0, VECS[i].hi, VECS[i].stat, VECS[i].dat[7:0], i % 2, 0, 16'h0, got);
                3'd1: begin
                    host_xfer(1'b1, VECS[i].hi, VECS[i].stat, 8'h00, i % 2, 0, 16'h0, got);
                    chk(got == VECS[i].exp, $sformatf("table row %0d R3 R4 R7 R8 R9 read", i),
                        32'(got), 32'(VECS[i].exp));
                end
                3'd2: core_load(VECS[i].dat);
                default: begin
                    chk(core_in_word == VECS[i].dat, $sformatf("table row %0d R5 R6 R9 word", i),
                        32'(core_in_word), 32'(VECS[i].dat));
                    core_take();
                end
            endcase
        end

        // R3 select captured at open, change mid-transfer ignored
        do_reset();
        core_load(16'h1122);
        @(negedge clk); hp_hi = 1'b0; hp_stat = 1'b0; hp_sel_n = 1'b0; hp_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(hp_data_o == 8'h22, "R3 low half", 32'(hp_data_o), 32'h22);
        hp_hi = 1'b1;
        repeat (6) @(negedge clk);
        chk(hp_data_o == 8'h22, "R3 select held during transfer", 32'(hp_data_o), 32'h22);
        hp_sel_n = 1'b1; hp_rd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(core_out_full == 1'b1, "R7 low read keeps flag", 32'(core_out_full), 32'h1);

        // R7 load in the same cycle as the high-half read close
        host_xfer(1'b1, 1'b1, 1'b0, 8'h00, 0, 1, 16'hBEEF, got);
        chk(got == 8'h11, "R3 high half before reload", 32'(got), 32'h11);
        host_xfer(1'b1, 1'b0, 1'b1, 8'h00, 1, 0, 16'h0, got);
        chk(got == 8'h02, "R7 load wins over clear", 32'(got), 32'h02);
        host_xfer(1'b1, 1'b0, 1'b0, 8'h00, 0, 0, 16'h0, got);
        chk(got == 8'hEF, "R7 reloaded word", 32'(got), 32'hEF);

        // R8 take in the same cycle as a commit
        do_reset();
        host_xfer(1'b0, 1'b0, 1'b0, 8'h01, 0, 0, 16'h0, got);
        host_xfer(1'b0, 1'b1, 1'b0, 8'h02, 1, 0, 16'h0, got);
        chk(core_in_word == 16'h0201, "R5 first word", 32'(core_in_word), 32'h0201);
        host_xfer(1'b0, 1'b0, 1'b0, 8'h03, 1, 0, 16'h0, got);
        host_xfer(1'b0, 1'b1, 1'b0, 8'h04, 0, 2, 16'h0, got);
        host_xfer(1'b1, 1'b0, 1'b1, 8'h00, 0, 0, 16'h0, got);
        chk(got == 8'h01, "R8 commit wins over take, no overrun", 32'(got), 32'h01);
        chk(core_in_word == 16'h0403, "R8 second word", 32'(core_in_word), 32'h0403);
        core_take();
        chk(core_in_full == 1'b0, "R8 take clears", 32'(core_in_full), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule